// File: doc/BRIEF.md
# Read-Once Device Secret Store

This block keeps a 256-bit device secret as eight 32-bit word registers. It sits behind a word-addressed read port on a memory-mapped bus. The secret comes from a parameter and is loaded into the word registers by the power-on reset. Each word gives its true value on only one read. After that read the word is wiped and every later read of it returns zero, until the next power-on reset loads the words again.

A mode input says whether the requester runs privileged firmware or an application. Reads made in application mode always return zero and leave the word intact, so firmware can still collect it later. Moving between the two modes never re-arms a wiped word. A read strobe is answered one cycle later with a single-cycle valid pulse and the registered data. Per-lane byte enables mask the returned data. A partial read still uses up the whole word, so software has to fetch each word as one 32-bit access.

Top module: `secret_once_store`

## Requirements
- R1: While the power-on reset is asserted and after it is released, `rd_valid` is 0 and `rd_data` is 0 until the first read strobe.
- R2: Every cycle with `rd_req` high is followed in the next cycle by `rd_valid` high for exactly that cycle, in either mode; `rd_valid` is low after a cycle without `rd_req`.
- R3: The first firmware-mode (`fw_mode`=1) read of word i with all byte enables set returns bits [32*i+31 : 32*i] of the `SECRET` parameter.
- R4: Every later firmware-mode read of a word that has already been read in firmware mode returns zero.
- R5: An application-mode (`fw_mode`=0) read returns zero and does not use up the word, so a later firmware-mode read of that word returns its secret value.
- R6: Reading a word uses up only that word; other words keep their values.
- R7: Bit k of `rd_be` enables byte lane k (data bits 8k+7:8k). Disabled lanes read as zero. A firmware-mode read with any lane pattern uses up the whole word, so a later read of other lanes at that address returns zero.
- R8: Toggling `fw_mode` never restores a used word; only the power-on reset re-arms all words.
- R9: `rd_data` is zero in every cycle in which `rd_valid` is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| por_n | input | 1 | Asynchronous power-on reset, active low; reloads and re-arms all words |
| fw_mode | input | 1 | 1 = privileged firmware mode, 0 = application mode |
| rd_req | input | 1 | Read strobe, one cycle per access |
| rd_addr | input | AW | Word index of the read |
| rd_be | input | WORD_W/8 | Byte-lane enables of the read |
| rd_valid | output | 1 | One-cycle pulse one cycle after `rd_req` |
| rd_data | output | WORD_W | Registered read data, zero when `rd_valid` is low |

## Verification
The assertions take for granted that `rd_addr` stays below the word count and that `fw_mode`, `rd_addr` and `rd_be` are steady around the clock edge that samples a strobe. The checker keeps its own record of which addresses firmware has read, built only from the port traffic. The bench changes inputs only on falling edges and only uses word indices 0 to 7. It switches modes between reads, never during a strobe, and applies the power-on reset only when no response is outstanding.

// File: rtl/secret_once_store.sv
module secret_once_store #(
  parameter int unsigned NWORDS = 8,
  parameter int unsigned WORD_W = 32,
  parameter logic [NWORDS*WORD_W-1:0] SECRET =
    256'h0f1e2d3c_4b5a6978_8796a5b4_c3d2e1f0_13579bdf_2468ace0_deadbeef_cafef00d,
  localparam int unsigned LANES = WORD_W / 8,
  localparam int unsigned AW = (NWORDS > 1) ? $clog2(NWORDS) : 1
) (
  input  logic              clk,
  input  logic              por_n,
  input  logic              fw_mode,
  input  logic              rd_req,
  input  logic [AW-1:0]     rd_addr,
  input  logic [LANES-1:0]  rd_be,
  output logic              rd_valid,
  output logic [WORD_W-1:0] rd_data
);

  logic [WORD_W-1:0] word_q [NWORDS];
  logic [NWORDS-1:0] used_q;
  logic [WORD_W-1:0] lane_mask;
  logic [WORD_W-1:0] word_sel;
  logic              addr_ok;
  logic              take;

  assign addr_ok = 32'(rd_addr) < NWORDS;
  assign take    = rd_req && fw_mode && addr_ok;

  for (genvar k = 0; k < LANES; k++) begin : g_lane
    assign lane_mask[8*k +: 8] = {8{rd_be[k]}};
  end

  always_comb begin
    word_sel = '0;
    if (addr_ok && !used_q[rd_addr]) word_sel = word_q[rd_addr];
  end

  for (genvar i = 0; i < NWORDS; i++) begin : g_word
    always_ff @(posedge clk or negedge por_n) begin
      if (!por_n) begin
        word_q[i] <= SECRET[WORD_W*i +: WORD_W];
        used_q[i] <= 1'b0;
      end else if (take && 32'(rd_addr) == i) begin
        word_q[i] <= '0;
        used_q[i] <= 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n) begin
      rd_valid <= 1'b0;
      rd_data  <= '0;
    end else begin
      rd_valid <= rd_req;
      rd_data  <= take ? (word_sel & lane_mask) : '0;
    end
  end

endmodule

module secret_once_store_chk #(
  parameter int unsigned NWORDS = 8,
  parameter int unsigned WORD_W = 32,
  localparam int unsigned LANES = WORD_W / 8,
  localparam int unsigned AW = (NWORDS > 1) ? $clog2(NWORDS) : 1
) (
  input logic              clk,
  input logic              por_n,
  input logic              fw_mode,
  input logic              rd_req,
  input logic [AW-1:0]     rd_addr,
  input logic [LANES-1:0]  rd_be,
  input logic              rd_valid,
  input logic [WORD_W-1:0] rd_data
);

  logic [NWORDS-1:0] seen;
  logic [WORD_W-1:0] be_mask;

  for (genvar k = 0; k < LANES; k++) begin : g_m
    assign be_mask[8*k +: 8] = {8{rd_be[k]}};
  end

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n) seen <= '0;
    else if (rd_req && fw_mode) seen[rd_addr] <= 1'b1;
  end

  p_reset_quiet_r1: assert property (@(posedge clk) !por_n |=> !rd_valid);
  p_valid_after_req_r2: assert property (@(posedge clk) disable iff (!por_n) rd_req |=> rd_valid);
  p_no_stray_valid_r2: assert property (@(posedge clk) disable iff (!por_n) !rd_req |=> !rd_valid);
  p_used_word_zero_r4: assert property (@(posedge clk) disable iff (!por_n)
    (rd_req && fw_mode && seen[rd_addr]) |=> rd_data == '0);
  p_app_read_zero_r5: assert property (@(posedge clk) disable iff (!por_n)
    (rd_req && !fw_mode) |=> rd_data == '0);
  p_lane_mask_r7: assert property (@(posedge clk) disable iff (!por_n)
    rd_req |=> (rd_data & ~$past(be_mask)) == '0);
  p_idle_data_zero_r9: assert property (@(posedge clk) disable iff (!por_n)
    !rd_valid |-> rd_data == '0);

endmodule

bind secret_once_store secret_once_store_chk #(.NWORDS(NWORDS), .WORD_W(WORD_W)) u_chk (
  .clk(clk), .por_n(por_n), .fw_mode(fw_mode), .rd_req(rd_req), .rd_addr(rd_addr),
  .rd_be(rd_be), .rd_valid(rd_valid), .rd_data(rd_data)
);

// File: tb/secret_once_store_tb.sv
module secret_once_store_tb;
  localparam int NW = 8;
  localparam logic [255:0] KEY =
    256'h11223344_a5a55a5a_0badc0de_77665544_f00dface_89abcdef_01234567_c0ffee99;

  logic clk = 0;
  logic por_n = 0;
  logic fw_mode = 0;
  logic rd_req = 0;
  logic [2:0] rd_addr = '0;
  logic [3:0] rd_be = '0;
  logic rd_valid;
  logic [31:0] rd_data;

  int checks = 0;
  int errors = 0;
  logic [NW-1:0] used = '0;
  logic [31:0] exp_q[$];
  string tag_q[$];
  bit done = 0;

  always #2.5 clk = ~clk;

  secret_once_store #(.NWORDS(NW), .WORD_W(32), .SECRET(KEY)) u_dut (
    .clk(clk), .por_n(por_n), .fw_mode(fw_mode), .rd_req(rd_req), .rd_addr(rd_addr),
    .rd_be(rd_be), .rd_valid(rd_valid), .rd_data(rd_data)
  );

  function automatic logic [31:0] mask_of(logic [3:0] be);
    return {{8{be[3]}}, {8{be[2]}}, {8{be[1]}}, {8{be[0]}}};
  endfunction

  task automatic check(bit ok, string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic rd(int a, logic [3:0] be, bit fw, string tag);
    logic [31:0] e;
    e = (fw && !used[a]) ? (KEY[32*a +: 32] & mask_of(be)) : 32'h0;
    if (fw) used[a] = 1'b1;
    exp_q.push_back(e);
    tag_q.push_back(tag);
    fw_mode = fw;
    rd_addr = 3'(a);
    rd_be = be;
    rd_req = 1;
    @(negedge clk);
    rd_req = 0;
  endtask

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  always @(negedge clk) begin
    if (por_n) begin
      if (rd_valid) begin
        if (exp_q.size() == 0) check(0, "R2 unexpected valid", 32'h1, 32'h0);
        else begin
          logic [31:0] e;
          string t;
          e = exp_q.pop_front();
          t = tag_q.pop_front();
          check(rd_data === e, t, rd_data, e);
        end
      end else if (rd_data !== 32'h0) begin
        check(0, "R9 data while idle", rd_data, 32'h0);
      end
    end
  end

  initial begin
    idle(3);
    check(rd_valid === 1'b0, "R1 valid in reset", 32'(rd_valid), 32'h0);
    check(rd_data === 32'h0, "R1 data in reset", rd_data, 32'h0);
    por_n = 1;
    idle(2);
    check(rd_valid === 1'b0 && rd_data === 32'h0, "R1 after release", rd_data, 32'h0);

    for (int a = 0; a < NW; a++) rd(a, 4'hf, 0, "R5 app read zero");
    idle(2);
    rd(2, 4'hf, 1, "R3 first fw read word2");
    rd(2, 4'hf, 1, "R4 second fw read word2");
    rd(3, 4'hf, 1, "R6 neighbour word3 intact");
    idle(1);
    rd(5, 4'b0001, 1, "R7 lane0 only");
    rd(5, 4'b0010, 1, "R7 lane1 after partial read");
    rd(6, 4'b1010, 1, "R7 lanes 1 and 3");
    rd(0, 4'hf, 0, "R5 app read word0");
    rd(0, 4'hf, 1, "R5 fw read after app read");
    rd(2, 4'hf, 0, "R8 app read used word");
    rd(2, 4'hf, 1, "R8 fw read after mode toggle");
    rd(1, 4'hf, 1, "R3 word1");
    rd(4, 4'hf, 1, "R3 word4");
    rd(7, 4'hf, 1, "R3 word7");
    for (int a = 0; a < NW; a++) rd(a, 4'hf, 1, "R4 all used");
    idle(3);
    check(exp_q.size() == 0, "R2 responses outstanding", 32'(exp_q.size()), 32'h0);

    por_n = 0;
    used = '0;
    idle(2);
    check(rd_valid === 1'b0 && rd_data === 32'h0, "R1 second reset", rd_data, 32'h0);
    por_n = 1;
    idle(1);
    rd(2, 4'hf, 1, "R8 reset re-arms word2");
    rd(5, 4'hf, 1, "R8 reset re-arms word5");
    rd(5, 4'hf, 1, "R4 word5 used again");
    idle(3);
    check(exp_q.size() == 0, "R2 responses outstanding", 32'(exp_q.size()), 32'h0);
    done = 1;
  end

  initial begin
    int n;
    n = 0;
    while (!done && n < 5000) begin
      @(posedge clk);
      n++;
    end
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired actual=%0d expected=done", n);
    end
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule